// File: doc/BRIEF.md
# Polynomial Splitting Test Engine

This block decides whether a monic polynomial of degree nine over GF(2^16) factors into nine distinct linear terms over that field. A polynomial of this kind splits that way exactly when z raised to the field size, reduced modulo the polynomial, equals z. The block computes that power by repeated squaring of residues and then compares the result with z.

The caller supplies the nine low coefficients of the polynomial. The leading coefficient is always one and is not carried on the port. The caller then pulses a start strobe. The block first builds four reduction residues, the remainders of z^10, z^12, z^14 and z^16. It gets them by stepping a degree-8 residue by z, one coefficient per cycle. It then runs twelve squarings on the shared multiplier. Each squaring places the squared low coefficients and then adds the four high coefficients, each squared and weighted by its reduction residue. A done strobe marks the cycle in which the final residue and the one-bit verdict are valid.

Top module: `pst_split_test`

## Requirements
- R1: While reset is asserted and after it is released, done_o and ok_o are 0 and residue_o is all zero until the first accepted start.
- R2: Coefficient j of the polynomial (j = 0..8) is carried on sigma_i bits [16j+15:16j], and the z^9 coefficient is implicitly 1. Coefficient j of the residue is carried on residue_o bits [16j+15:16j].
- R3: When done_o is high, residue_o equals z^65536 mod sigma, computed with the field polynomial FPOLY (default x^16+x^12+x^3+x+1).
- R4: ok_o is high only while done_o is high, and then exactly when the residue is 1 at coefficient 1 and 0 at every other coefficient.
- R5: A polynomial built from nine distinct field elements as roots yields ok_o = 1. A polynomial with a repeated root, or z^9 itself, yields ok_o = 0.
- R6: done_o is high for exactly one cycle: the cycle that follows the 632nd rising edge after the edge that accepted start.
- R7: A start that is high while a run is in progress, including in the done cycle, is ignored. sigma_i is sampled only on the accepting edge, so later changes on sigma_i have no effect. A new start is accepted from the cycle after done.
- R8: residue_o holds its value from the done cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled only while idle |
| sigma_i | input | 144 | Nine low coefficients of the monic polynomial |
| done_o | output | 1 | One-cycle strobe marking a valid result |
| ok_o | output | 1 | Verdict: the polynomial has nine distinct roots |
| residue_o | output | 144 | Final residue z^65536 mod sigma |

## Verification
The engine is tried with two split polynomials. One has small roots. The other has roots that include zero and field elements with their top bit set, so that every bit of the reduction path is exercised. Both must reach residue z. A polynomial with a double root and an arbitrary coefficient pattern must give residues that are not z. Because the bench model computes the exact residue independently, a wrong reduction or phi value shows up even where the verdict happens to agree. The z^9 case drives every residue to zero and separates a correct shift-in from a stuck leading coefficient. Start pulses in the middle of a run and in the done cycle, each carrying a different polynomial, check that a run cannot be restarted or corrupted.

// File: rtl/pst_pkg.sv
package pst_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PRE,
      PH_BASE,
      PH_HIGH,
      PH_COPY,
      PH_FIN
   } phase_t;
endpackage

// File: rtl/pst_gf_mul.sv
// Combinational GF(2^FW) multiplier, shift-and-add over the bits of b.
module pst_gf_mul #(
   parameter int FW = 16,
   parameter logic [FW:0] FPOLY = 17'h1100B
) (
   input  logic [FW-1:0] a,
   input  logic [FW-1:0] b,
   output logic [FW-1:0] p
);
   localparam logic [FW-1:0] RED = FPOLY[FW-1:0];

   always_comb begin
      logic [FW-1:0] sh;
      logic [FW-1:0] sum;
      sh  = a;
      sum = '0;
      for (int i = 0; i < FW; i++) begin
         if (b[i]) sum = sum ^ sh;
         sh = {sh[FW-2:0], 1'b0} ^ ({FW{sh[FW-1]}} & RED);
      end
      p = sum;
   end
endmodule

// File: rtl/pst_seq.sv
// Phase sequencer: precompute steps, then base + high passes per squaring.
module pst_seq
   import pst_pkg::*;
#(
   parameter int T    = 9,
   parameter int NSQ  = 12,
   parameter int LOWN = 5,
   parameter int NPHI = 4,
   parameter int CW   = 4,
   parameter int SW   = 4,
   parameter int QW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output phase_t        phase_o,
   output logic [CW-1:0] cnt_o,
   output logic [SW-1:0] stp_o
);
   localparam logic [CW-1:0] C_LAST  = CW'(T);
   localparam logic [CW-1:0] C_BLAST = CW'(LOWN - 1);
   localparam logic [SW-1:0] S_PLAST = SW'(T - 1);
   localparam logic [SW-1:0] S_HLAST = SW'(NPHI - 1);
   localparam logic [QW-1:0] Q_INIT  = QW'(NSQ);
   localparam logic [QW-1:0] Q_ONE   = QW'(1);

   logic [QW-1:0] sq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_o <= PH_IDLE;
         cnt_o   <= '0;
         stp_o   <= '0;
         sq_q    <= '0;
      end else begin
         case (phase_o)
            PH_IDLE: if (start_i) begin
               phase_o <= PH_PRE;
               cnt_o   <= '0;
               stp_o   <= SW'(1);
            end
            PH_PRE: if (cnt_o == C_LAST) begin
               cnt_o <= '0;
               if (stp_o == S_PLAST) begin
                  phase_o <= PH_BASE;
                  stp_o   <= '0;
                  sq_q    <= Q_INIT;
               end else begin
                  stp_o <= stp_o + 1'b1;
               end
            end else begin
               cnt_o <= cnt_o + 1'b1;
            end
            PH_BASE: if (cnt_o == C_BLAST) begin
               phase_o <= PH_HIGH;
               cnt_o   <= '0;
               stp_o   <= '0;
            end else begin
               cnt_o <= cnt_o + 1'b1;
            end
            PH_HIGH: if (cnt_o == C_LAST) begin
               cnt_o <= '0;
               if (stp_o == S_HLAST) phase_o <= PH_COPY;
               else                  stp_o   <= stp_o + 1'b1;
            end else begin
               cnt_o <= cnt_o + 1'b1;
            end
            PH_COPY: if (sq_q == Q_ONE) begin
               phase_o <= PH_FIN;
            end else begin
               sq_q    <= sq_q - 1'b1;
               phase_o <= PH_BASE;
            end
            PH_FIN:  phase_o <= PH_IDLE;
            default: phase_o <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pst_split_test.sv
// Splitting test: z^(2^FW) mod sigma by residue squaring, compared with z.
module pst_split_test
   import pst_pkg::*;
#(
   parameter int FW = 16,
   parameter int T  = 9,
   parameter logic [FW:0] FPOLY = 17'h1100B
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [T*FW-1:0] sigma_i,
   output logic            done_o,
   output logic            ok_o,
   output logic [T*FW-1:0] residue_o
);
   localparam int LOWN = (T + 1) / 2;
   localparam int HI0  = LOWN;
   localparam int NPHI = T - LOWN;
   localparam int LG   = $clog2(2 * (T - 1));
   localparam int NSQ  = FW - LG;
   localparam int CW   = $clog2(T + 1);
   localparam int SW   = (T > 2) ? $clog2(T) : 1;
   localparam int QW   = $clog2(NSQ + 1);

   // elaboration-time parameter checks
   if (T < 3 || (T % 2) == 0) begin : g_bad_t
      $error("pst_split_test: T must be odd and at least 3");
   end
   if ((1 << LG) != 2 * (T - 1)) begin : g_bad_pow
      $error("pst_split_test: 2*(T-1) must be a power of two");
   end
   if (NSQ < 1) begin : g_bad_nsq
      $error("pst_split_test: field too small for this degree");
   end
   if (FPOLY[FW] != 1'b1 || FPOLY[0] != 1'b1) begin : g_bad_poly
      $error("pst_split_test: FPOLY must have degree FW and a constant term");
   end

   phase_t        phase;
   logic [CW-1:0] cnt;
   logic [SW-1:0] stp;
   int            cnt_n;
   int            stp_n;

   pst_seq #(
      .T(T), .NSQ(NSQ), .LOWN(LOWN), .NPHI(NPHI),
      .CW(CW), .SW(SW), .QW(QW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .phase_o(phase), .cnt_o(cnt), .stp_o(stp)
   );

   assign cnt_n = int'(cnt);
   assign stp_n = int'(stp);

   logic [FW-1:0] sig_in [T];
   logic [FW-1:0] sig_q  [T];
   logic [FW-1:0] res_q  [T];
   logic [FW-1:0] acc_q  [T];
   logic [FW-1:0] phi_q  [NPHI][T];
   logic [FW-1:0] sq_q;
   logic [FW-1:0] lead_q;
   logic [FW-1:0] ma, mb, prod;
   logic [T*FW-1:0] sig_flat;

   for (genvar g = 0; g < T; g++) begin : g_pack
      assign sig_in[g]               = sigma_i[g*FW +: FW];
      assign residue_o[g*FW +: FW]   = res_q[g];
      assign sig_flat[g*FW +: FW]    = sig_q[g];
   end

   pst_gf_mul #(.FW(FW), .FPOLY(FPOLY)) u_mul (.a(ma), .b(mb), .p(prod));

   // operand selection for the shared multiplier
   always_comb begin
      ma = '0;
      mb = '0;
      case (phase)
         PH_PRE: for (int k = 0; k < T; k++) begin
            if (k == T - 1 - cnt_n) begin
               ma = (cnt_n == 0) ? res_q[T-1] : lead_q;
               mb = sig_q[k];
            end
         end
         PH_BASE: for (int k = 0; k < LOWN; k++) begin
            if (k == cnt_n) begin
               ma = res_q[k];
               mb = res_q[k];
            end
         end
         PH_HIGH: begin
            if (cnt_n == 0) begin
               for (int h = 0; h < NPHI; h++) begin
                  if (h == stp_n) begin
                     ma = res_q[HI0+h];
                     mb = res_q[HI0+h];
                  end
               end
            end else begin
               ma = sq_q;
               for (int h = 0; h < NPHI; h++) begin
                  for (int k = 0; k < T; k++) begin
                     if (h == stp_n && k == cnt_n - 1) mb = phi_q[h][k];
                  end
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sq_q   <= '0;
         lead_q <= '0;
         for (int k = 0; k < T; k++) begin
            sig_q[k] <= '0;
            res_q[k] <= '0;
            acc_q[k] <= '0;
            for (int h = 0; h < NPHI; h++) phi_q[h][k] <= '0;
         end
      end else begin
         case (phase)
            PH_IDLE: if (start_i) begin
               for (int k = 0; k < T; k++) begin
                  sig_q[k] <= sig_in[k];
                  res_q[k] <= (k == T - 1) ? FW'(1) : '0;
                  acc_q[k] <= '0;
               end
            end
            PH_PRE: begin
               if (cnt_n < T) begin
                  // multiply residue by z, fold the z^T term back
                  if (cnt_n == 0) lead_q <= res_q[T-1];
                  if (cnt_n == T - 1) res_q[0] <= prod;
                  for (int k = 1; k < T; k++) begin
                     if (k == T - 1 - cnt_n) res_q[k] <= res_q[k-1] ^ prod;
                  end
               end else begin
                  for (int h = 0; h < NPHI; h++) begin
                     if (T - 1 + stp_n == 2 * (HI0 + h)) begin
                        for (int k = 0; k < T; k++) phi_q[h][k] <= res_q[k];
                     end
                  end
               end
            end
            PH_BASE: for (int k = 0; k < LOWN; k++) begin
               if (k == cnt_n) acc_q[2*k] <= prod;
            end
            PH_HIGH: begin
               if (cnt_n == 0) begin
                  sq_q <= prod;
               end else begin
                  for (int k = 0; k < T; k++) begin
                     if (k == cnt_n - 1) acc_q[k] <= acc_q[k] ^ prod;
                  end
               end
            end
            PH_COPY: for (int k = 0; k < T; k++) begin
               res_q[k] <= acc_q[k];
               acc_q[k] <= '0;
            end
            default: ;
         endcase
      end
   end

   logic is_z;
   always_comb begin
      is_z = 1'b1;
      for (int k = 0; k < T; k++) begin
         if (res_q[k] != ((k == 1) ? FW'(1) : FW'(0))) is_z = 1'b0;
      end
   end

   assign done_o = (phase == PH_FIN);
   assign ok_o   = done_o & is_z;
endmodule

// File: rtl/pst_split_test_chk.sv
// Protocol checker, bound to the top module.
module pst_split_test_chk #(
   parameter int FW = 16,
   parameter int T  = 9
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic            done_o,
   input logic            ok_o,
   input logic [T*FW-1:0] residue_o,
   input logic [T*FW-1:0] sig_flat
);
   localparam int LOWN = (T + 1) / 2;
   localparam int NPHI = T - LOWN;
   localparam int NSQ  = FW - $clog2(2 * (T - 1));
   localparam int LAT  = (T - 1) * (T + 1) + NSQ * (LOWN + NPHI * (T + 1) + 1);

   logic        run_q;
   logic [31:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (!run_q) begin
         if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= '0;
         end
      end else begin
         if (cnt_q == 32'(LAT)) run_q <= 1'b0;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assert_done_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o == (run_q && cnt_q == 32'(LAT)));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_flag_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ok_o |-> done_o);

   assert_sigma_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> $stable(sig_flat));

   assert_residue_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((!run_q && !start_i) || done_o) |=> $stable(residue_o));
endmodule

bind pst_split_test pst_split_test_chk #(.FW(FW), .T(T)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
   .ok_o(ok_o), .residue_o(residue_o), .sig_flat(sig_flat)
);

// File: tb/pst_split_test_tb_top.sv
module pst_split_test_tb_top;
   localparam int FW  = 16;
   localparam int T   = 9;
   localparam int LAT = 632;   // R6
   localparam logic [FW-1:0] RED = 16'h100B;
   localparam logic [T*FW-1:0] ZPOLY = {{((T-2)*FW){1'b0}}, 16'h0001, 16'h0000};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [T*FW-1:0] sigma = '0;
   logic            done_o, ok_o;
   logic [T*FW-1:0] residue_o;

   int n_cmp = 0;
   int n_bad = 0;
   int n_done = 0;
   logic seen_ok = 1'b0;

   always #5 clk = ~clk;

   pst_split_test dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .sigma_i(sigma),
      .done_o(done_o), .ok_o(ok_o), .residue_o(residue_o)
   );

   function automatic logic [FW-1:0] gfm(input logic [FW-1:0] a, input logic [FW-1:0] b);
      logic [FW-1:0] r;
      r = '0;
      for (int i = FW - 1; i >= 0; i--) begin
         r = {r[FW-2:0], 1'b0} ^ (r[FW-1] ? RED : '0);
         if (b[i]) r = r ^ a;
      end
      return r;
   endfunction

   // z^(2^FW) mod (z^T + sum s_j z^j), by FW squarings starting from z
   function automatic logic [T*FW-1:0] ref_pow(input logic [T*FW-1:0] s);
      logic [FW-1:0] r [T];
      logic [FW-1:0] pr [2*T-1];
      logic [FW-1:0] c;
      logic [T*FW-1:0] out;
      for (int j = 0; j < T; j++) r[j] = '0;
      r[1] = 16'h0001;
      for (int it = 0; it < FW; it++) begin
         for (int d = 0; d < 2*T-1; d++) pr[d] = '0;
         for (int i = 0; i < T; i++)
            for (int j = 0; j < T; j++) pr[i+j] = pr[i+j] ^ gfm(r[i], r[j]);
         for (int d = 2*T-2; d >= T; d--) begin
            c = pr[d];
            pr[d] = '0;
            for (int j = 0; j < T; j++) pr[d-T+j] = pr[d-T+j] ^ gfm(c, s[j*FW +: FW]);
         end
         for (int j = 0; j < T; j++) r[j] = pr[j];
      end
      for (int j = 0; j < T; j++) out[j*FW +: FW] = r[j];
      return out;
   endfunction

   // low coefficients of prod (z + a_k) over the given roots
   function automatic logic [T*FW-1:0] from_roots(input logic [T*FW-1:0] rts);
      logic [FW-1:0] c [T+1];
      logic [FW-1:0] a;
      logic [T*FW-1:0] out;
      for (int j = 0; j <= T; j++) c[j] = '0;
      c[0] = 16'h0001;
      for (int k = 0; k < T; k++) begin
         a = rts[k*FW +: FW];
         for (int j = T; j >= 1; j--) c[j] = c[j-1] ^ gfm(a, c[j]);
         c[0] = gfm(a, c[0]);
      end
      for (int j = 0; j < T; j++) out[j*FW +: FW] = c[j];
      return out;
   endfunction

   task automatic check1(input bit good, input string tag, input logic act, input logic exp);
      n_cmp++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic checkv(input bit good, input string tag, input logic [T*FW-1:0] act,
                         input logic [T*FW-1:0] exp);
      n_cmp++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference: run window and expected residue
   logic            m_run = 1'b0;
   int              m_cnt = 0;
   logic [T*FW-1:0] m_exp = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run <= 1'b0;
         m_cnt <= 0;
      end else if (!m_run) begin
         if (start) begin
            m_run <= 1'b1;
            m_cnt <= 0;
            m_exp <= ref_pow(sigma);
         end
      end else begin
         if (m_cnt == LAT) m_run <= 1'b0;
         m_cnt <= m_cnt + 1;
      end
   end

   // per-clock comparison
   always @(negedge clk) begin
      logic e_done;
      logic e_ok;
      if (rst_n) begin
         e_done = m_run && (m_cnt == LAT);
         check1(done_o === e_done, "R6 done timing", done_o, e_done);
         if (e_done) begin
            e_ok = (m_exp == ZPOLY);
            checkv(residue_o === m_exp, "R3 residue", residue_o, m_exp);
            check1(ok_o === e_ok, "R4 verdict", ok_o, e_ok);
            n_done++;
            seen_ok = ok_o;
         end else begin
            check1(ok_o === 1'b0, "R4 verdict outside done", ok_o, 1'b0);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic run_case(input logic [T*FW-1:0] sig, input int want, input string tag);
      int d0;
      tick();
      while (m_run) tick();
      d0 = n_done;
      sigma = sig;
      start = 1'b1;
      tick();
      start = 1'b0;
      while (m_run) tick();
      check1(n_done == d0 + 1, "R6 one done per run", 1'(n_done - d0), 1'b1);
      if (want >= 0)
         check1(seen_ok == 1'(want), tag, seen_ok, 1'(want));
   endtask

   logic [T*FW-1:0] rts, sA, sB, sC, sD, sE;
   int d1;

   initial begin
      for (int k = 0; k < T; k++) rts[k*FW +: FW] = FW'(k + 1);
      sA = from_roots(rts);
      rts = {16'h4321, 16'h7777, 16'h00FF, 16'h0F0F, 16'hABCD,
             16'h1234, 16'h8000, 16'hFFFF, 16'h0000};
      sB = from_roots(rts);
      rts = {16'd11, 16'd10, 16'd9, 16'd8, 16'd7, 16'd6, 16'd5, 16'd3, 16'd3};
      sC = from_roots(rts);
      sD = '0;
      sE = {16'h9E37, 16'h79B9, 16'h7F4A, 16'h7C15, 16'hF39C,
            16'hC060, 16'h5A3B, 16'h2D1E, 16'h1F2B};

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check1(done_o === 1'b0, "R1 done in reset", done_o, 1'b0);
      check1(ok_o === 1'b0, "R1 ok in reset", ok_o, 1'b0);
      checkv(residue_o === '0, "R1 residue in reset", residue_o, '0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (4) tick();
      checkv(residue_o === '0, "R1 residue after reset", residue_o, '0);

      // R2 R3 R5: distinct small roots split
      run_case(sA, 1, "R5 distinct small roots");
      // R5: distinct roots incl. zero and high-bit elements
      run_case(sB, 1, "R5 distinct wide roots");
      // R5: repeated root
      run_case(sC, 0, "R5 repeated root");
      // R5: sigma = z^9, residue collapses to zero
      run_case(sD, 0, "R5 pure power");
      checkv(residue_o === '0, "R3 pure power residue", residue_o, '0);
      // R3: arbitrary coefficients, residue checked by model
      run_case(sE, -1, "R3 arbitrary");

      // R7: start pulses during a run and in the done cycle are ignored
      tick();
      d1 = n_done;
      sigma = sA;
      start = 1'b1;
      tick();
      start = 1'b0;
      repeat (100) tick();
      sigma = sE;
      start = 1'b1;
      tick();
      start = 1'b0;
      sigma = sC;
      while (!(m_run && m_cnt == LAT)) tick();
      start = 1'b1;
      tick();
      start = 1'b0;
      repeat (700) tick();
      check1(n_done == d1 + 1, "R7 no restart", 1'(n_done - d1), 1'b1);
      check1(seen_ok == 1'b1, "R7 first sigma kept", seen_ok, 1'b1);
      // R8: residue held long after done
      checkv(residue_o === ref_pow(sA), "R8 residue held", residue_o, ref_pow(sA));

      // R7: accepted again after idle
      run_case(sB, 1, "R7 accepted after done");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule